// File: doc/BRIEF.md
# Debug Power and Reset Control Register

This block is a two-register control point that a debug host uses to bring a processor subsystem into a usable debug state. A control word drives wakeup requests for the core, memory and debug power domains, reset requests for the core and the debug logic, and a debug-access enable. A status word reports whether each domain is on, whether the core is still needed, and two sticky flags that record that the core or the debug logic has been reset since the host last cleared them.

The registers are 8 bits wide and are presented zero-extended on a 32-bit register bus with address, read strobe, write strobe and write data. Read data is returned one cycle after the read strobe. A read carries a clear mask: the sticky flags selected by the mask are cleared once their pre-clear value has been captured for return. The debug-access enable is deliberately hard to set. It is armed only by a 0-to-1 write made while debug reset is released and the other control bits already hold their wanted values. Any control write while it is set drops it, so the host must keep rewriting it. Downstream logic uses the enable to decide whether debug-path accesses count.

Domain-on and core-needed inputs and the two reset-event inputs come from other clock or power contexts. They pass through a synchroniser before they reach the status word.

Top module: `dbg_pwr_ctl`

## Requirements
- R1: After reset the control word is 0x00, every control output is 0, and the status word reads with core-was-reset (bit 4) and debug-was-reset (bit 6) set.
- R2: Control bits are core wakeup bit 0, memory wakeup bit 1, debug wakeup bit 2, core reset bit 4 and debug reset bit 6. A write stores them, drives the matching outputs and reads them back. Bits 3 and 5 read as 0. Without a control write the word does not change.
- R3: Debug-access enable (control bit 7) becomes 1 only on a control write with bit 7 = 1 while it is 0, with bit 6 = 0 both in the written value and in the current word, and with written bits 0, 1, 2 and 4 equal to the current ones. Any other write leaves it 0.
- R4: Any control write while debug-access enable is 1 clears it; the other control bits take the written value.
- R5: Status bits 0 (core on), 1 (memory on), 2 (debug on) and 3 (core still needed) follow their inputs through the synchroniser with no latching.
- R6: A core reset event sets status bit 4 and a debug reset event sets status bit 6; each stays set until cleared.
- R7: A read of the status word with clear-mask bit 4 or 6 set returns the pre-clear value and then clears the selected flag. A reset event still present in that cycle keeps the flag set.
- R8: Control is at byte offset 0x20 and status at 0x24. Read data appears the cycle after the read strobe and holds until the next read. Bits 31:8 are 0. Other offsets read 0, and writes to status or to other offsets change nothing.
- R9: The clear mask has no effect on bits other than 4 and 6, and no effect on a read of any address other than status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| clr_mask_i | input | 8 | Sticky-flag clear mask applied with a status read |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| core_on_i | input | 1 | Core domain is powered |
| mem_on_i | input | 1 | Memory domain is powered |
| dbg_on_i | input | 1 | Debug domain is powered |
| core_needed_i | input | 1 | Core is still required by the system |
| core_rst_evt_i | input | 1 | Core reset event |
| dbg_rst_evt_i | input | 1 | Debug logic reset event |
| core_wakeup_o | output | 1 | Core domain wakeup request |
| mem_wakeup_o | output | 1 | Memory domain wakeup request |
| dbg_wakeup_o | output | 1 | Debug domain wakeup request |
| core_reset_o | output | 1 | Core reset request |
| dbg_reset_o | output | 1 | Debug logic reset request |
| dbg_access_en_o | output | 1 | Debug register accesses are valid |

## Verification
On every cycle the assertions check three things: that the enable rises only after a qualifying write and falls after any write while it is set, that the control word and read data hold without a bus access, and that the sticky flags set on events, stay set, and clear only through a masked status read. What only the bench scenarios can show is the end-to-end bit layout, which is swept over all control write values and all domain-input combinations against a model built from the requirements. The bench also covers the read-before-clear ordering, an event racing a clear, and the address decode including ignored writes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int REG_W = 8;

  // control word bit positions
  localparam int C_CORE_WAKE = 0;
  localparam int C_MEM_WAKE  = 1;
  localparam int C_DBG_WAKE  = 2;
  localparam int C_CORE_RST  = 4;
  localparam int C_DBG_RST   = 6;
  localparam int C_DBG_EN    = 7;

  // status word bit positions
  localparam int S_CORE_ON   = 0;
  localparam int S_MEM_ON    = 1;
  localparam int S_DBG_ON    = 2;
  localparam int S_CORE_NEED = 3;
  localparam int S_CORE_WAS  = 4;
  localparam int S_DBG_WAS   = 6;

  localparam logic [REG_W-1:0] CTRL_STORE_MASK = 8'h57;
  localparam logic [REG_W-1:0] CTRL_MATCH_MASK = 8'h17;
endpackage

// File: rtl/dpr_sync.sv
module dpr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import dpr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             arm;

  // enable arms only on a clean 0->1 with debug reset released and other bits settled
  always_comb begin
    arm = !ctrl_q[C_DBG_EN] && wdata_i[C_DBG_EN] &&
          !wdata_i[C_DBG_RST] && !ctrl_q[C_DBG_RST] &&
          (((wdata_i ^ ctrl_q) & CTRL_MATCH_MASK) == '0);
    ctrl_d = wdata_i & CTRL_STORE_MASK;
    ctrl_d[C_DBG_EN] = arm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R4
  any_wr_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_q[C_DBG_EN]) |=> !ctrl_q[C_DBG_EN]);

  // R3
  en_rise_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q[C_DBG_EN]) |-> $past(wr_en_i && wdata_i[C_DBG_EN] &&
                                      !wdata_i[C_DBG_RST] && !ctrl_q[C_DBG_RST]));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));
endmodule

// File: rtl/dpr_stat.sv
module dpr_stat
  import dpr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       level_i,
  input  logic             core_evt_i,
  input  logic             dbg_evt_i,
  input  logic             clr_en_i,
  input  logic             clr_core_i,
  input  logic             clr_dbg_i,
  output logic [REG_W-1:0] stat_o
);
  logic core_was_q, dbg_was_q;
  logic core_clr, dbg_clr;

  assign core_clr = clr_en_i && clr_core_i;
  assign dbg_clr  = clr_en_i && clr_dbg_i;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_was_q <= 1'b1;
      dbg_was_q  <= 1'b1;
    end else begin
      core_was_q <= core_evt_i || (core_was_q && !core_clr);
      dbg_was_q  <= dbg_evt_i  || (dbg_was_q  && !dbg_clr);
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[S_CORE_ON]   = level_i[0];
    stat_o[S_MEM_ON]    = level_i[1];
    stat_o[S_DBG_ON]    = level_i[2];
    stat_o[S_CORE_NEED] = level_i[3];
    stat_o[S_CORE_WAS]  = core_was_q;
    stat_o[S_DBG_WAS]   = dbg_was_q;
  end

  // R6
  core_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_was_q && !core_clr) |=> core_was_q);
  // R6
  dbg_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_was_q && !dbg_clr) |=> dbg_was_q);
  // R6
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_evt_i || dbg_evt_i) |=> ((core_was_q || !$past(core_evt_i)) &&
                                   (dbg_was_q  || !$past(dbg_evt_i))));
  // R7
  core_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clr && !core_evt_i) |=> !core_was_q);
  // R7
  dbg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_clr && !dbg_evt_i) |=> !dbg_was_q);
endmodule

// File: rtl/dbg_pwr_ctl.sv
module dbg_pwr_ctl
  import dpr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CTRL_OFS    = 'h20,
  parameter int STAT_OFS    = 'h24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_W-1:0]  clr_mask_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              core_on_i,
  input  logic              mem_on_i,
  input  logic              dbg_on_i,
  input  logic              core_needed_i,
  input  logic              core_rst_evt_i,
  input  logic              dbg_rst_evt_i,
  output logic              core_wakeup_o,
  output logic              mem_wakeup_o,
  output logic              dbg_wakeup_o,
  output logic              core_reset_o,
  output logic              dbg_reset_o,
  output logic              dbg_access_en_o
);
  localparam int NSYNC = 6;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

  logic [NSYNC-1:0] raw_in, sync_in;
  logic [REG_W-1:0] ctrl, stat, rdata_q;
  logic             sel_ctrl, sel_stat;
  logic             unused_bits;

  assign unused_bits = ^{wdata_i[DATA_W-1:REG_W], clr_mask_i[7], clr_mask_i[5],
                         clr_mask_i[3:0]};

  assign raw_in = {dbg_rst_evt_i, core_rst_evt_i, core_needed_i, dbg_on_i, mem_on_i, core_on_i};

  dpr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign sel_ctrl = (addr_i == CTRL_ADDR);
  assign sel_stat = (addr_i == STAT_ADDR);

  dpr_ctrl i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_i && sel_ctrl),
    .wdata_i(wdata_i[REG_W-1:0]),
    .ctrl_o (ctrl)
  );

  dpr_stat i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (sync_in[3:0]),
    .core_evt_i(sync_in[4]),
    .dbg_evt_i (sync_in[5]),
    .clr_en_i  (rd_i && sel_stat),
    .clr_core_i(clr_mask_i[S_CORE_WAS]),
    .clr_dbg_i (clr_mask_i[S_DBG_WAS]),
    .stat_o    (stat)
  );

  // read data captures pre-clear status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (sel_ctrl)      rdata_q <= ctrl;
      else if (sel_stat) rdata_q <= stat;
      else               rdata_q <= '0;
    end
  end

  assign rdata_o = {{(DATA_W-REG_W){1'b0}}, rdata_q};

  assign core_wakeup_o   = ctrl[C_CORE_WAKE];
  assign mem_wakeup_o    = ctrl[C_MEM_WAKE];
  assign dbg_wakeup_o    = ctrl[C_DBG_WAKE];
  assign core_reset_o    = ctrl[C_CORE_RST];
  assign dbg_reset_o     = ctrl[C_DBG_RST];
  assign dbg_access_en_o = ctrl[C_DBG_EN];

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R8
  stat_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_ctrl) |=> $stable({dbg_access_en_o, dbg_reset_o, core_reset_o,
                                     dbg_wakeup_o, mem_wakeup_o, core_wakeup_o}));
endmodule

// File: tb/test_dbg_pwr_ctl.sv
module test_dbg_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  clr_mask_i = '0;
  logic [31:0] rdata_o;
  logic        core_on_i = 0, mem_on_i = 0, dbg_on_i = 0, core_needed_i = 0;
  logic        core_rst_evt_i = 0, dbg_rst_evt_i = 0;
  logic        core_wakeup_o, mem_wakeup_o, dbg_wakeup_o, core_reset_o, dbg_reset_o;
  logic        dbg_access_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  ctrl_m = '0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pwr_ctl i_dbg_pwr_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .clr_mask_i(clr_mask_i), .rdata_o(rdata_o),
    .core_on_i(core_on_i), .mem_on_i(mem_on_i), .dbg_on_i(dbg_on_i),
    .core_needed_i(core_needed_i), .core_rst_evt_i(core_rst_evt_i),
    .dbg_rst_evt_i(dbg_rst_evt_i), .core_wakeup_o(core_wakeup_o),
    .mem_wakeup_o(mem_wakeup_o), .dbg_wakeup_o(dbg_wakeup_o),
    .core_reset_o(core_reset_o), .dbg_reset_o(dbg_reset_o),
    .dbg_access_en_o(dbg_access_en_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_rd(logic [7:0] a, logic [7:0] m, output logic [31:0] d);
    @(negedge clk); addr_i = a; rd_i = 1; clr_mask_i = m;
    @(negedge clk); rd_i = 0; clr_mask_i = '0; d = rdata_o;
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] w);
    @(negedge clk); addr_i = a; wr_i = 1; wdata_i = w;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // spec model of a control write
  function automatic logic [7:0] ctrl_next(logic [7:0] c, logic [31:0] w);
    logic arm;
    arm = !c[7] && w[7] && !w[6] && !c[6] && (((w[7:0] ^ c) & 8'h17) == 8'h00);
    return (w[7:0] & 8'h57) | {arm, 7'b0};
  endfunction

  function automatic logic [31:0] outs();
    return {26'b0, dbg_access_en_o, dbg_reset_o, core_reset_o, dbg_wakeup_o,
            mem_wakeup_o, core_wakeup_o};
  endfunction

  function automatic logic [31:0] outs_exp(logic [7:0] c);
    return {26'b0, c[7], c[6], c[4], c[2], c[1], c[0]};
  endfunction

  task automatic wr_ctrl_chk(string req, logic [31:0] w);
    ctrl_m = ctrl_next(ctrl_m, w);
    do_wr(8'h20, w);
    chk(req, outs(), outs_exp(ctrl_m));
    do_rd(8'h20, 8'h00, rd);
    chk(req, rd, {24'b0, ctrl_m});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk("R1 outputs in reset", outs(), 32'h0);
    rst_ni = 1;
    wait_cyc(2);
    chk("R1 outputs after reset", outs(), 32'h0);
    do_rd(8'h20, 8'h00, rd); chk("R1 ctrl reset", rd, 32'h0);
    do_rd(8'h24, 8'h00, rd); chk("R1 status reset", rd, 32'h50);

    // R7 pre-clear value returned, then flags cleared
    do_rd(8'h24, 8'h50, rd); chk("R7 pre-clear value", rd, 32'h50);
    do_rd(8'h24, 8'h00, rd); chk("R7 flags cleared", rd, 32'h00);

    // R5 sweep of all domain inputs
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      {core_needed_i, dbg_on_i, mem_on_i, core_on_i} = 4'(d);
      wait_cyc(3);
      do_rd(8'h24, 8'h00, rd);
      chk("R5 domain level", rd, 32'(d));
    end
    @(negedge clk); {core_needed_i, dbg_on_i, mem_on_i, core_on_i} = 4'h0;
    wait_cyc(3);

    // R6 core event
    @(negedge clk); core_rst_evt_i = 1;
    @(negedge clk); core_rst_evt_i = 0;
    wait_cyc(4);
    do_rd(8'h24, 8'h00, rd); chk("R6 core event sets bit4", rd, 32'h10);
    wait_cyc(5);
    do_rd(8'h24, 8'h00, rd); chk("R6 core flag sticky", rd, 32'h10);
    // R9 mask on other bits / other address
    do_rd(8'h24, 8'hAF, rd); chk("R9 non-sticky mask read", rd, 32'h10);
    do_rd(8'h24, 8'h00, rd); chk("R9 non-sticky mask no clear", rd, 32'h10);
    do_rd(8'h20, 8'hFF, rd); chk("R9 mask on ctrl read", rd, 32'h00);
    do_rd(8'h24, 8'h00, rd); chk("R9 ctrl read no clear", rd, 32'h10);
    // R6 debug event
    @(negedge clk); dbg_rst_evt_i = 1;
    @(negedge clk); dbg_rst_evt_i = 0;
    wait_cyc(4);
    do_rd(8'h24, 8'h00, rd); chk("R6 debug event sets bit6", rd, 32'h50);
    // R7 selective clear
    do_rd(8'h24, 8'h40, rd); chk("R7 selective clear read", rd, 32'h50);
    do_rd(8'h24, 8'h00, rd); chk("R7 only bit6 cleared", rd, 32'h10);
    // R7 event present during clear wins
    @(negedge clk); core_rst_evt_i = 1;
    wait_cyc(4);
    do_rd(8'h24, 8'h10, rd); chk("R7 clear with event read", rd, 32'h10);
    do_rd(8'h24, 8'h00, rd); chk("R7 event wins over clear", rd, 32'h10);
    @(negedge clk); core_rst_evt_i = 0;
    wait_cyc(4);
    do_rd(8'h24, 8'h10, rd); chk("R7 clear after event", rd, 32'h10);
    do_rd(8'h24, 8'h00, rd); chk("R7 cleared after event", rd, 32'h00);

    // R8 decode
    do_rd(8'h28, 8'h00, rd); chk("R8 unmapped reads zero", rd, 32'h0);
    do_wr(8'h24, 32'hFFFF_FFFF);
    chk("R8 status write no output effect", outs(), 32'h0);
    do_rd(8'h20, 8'h00, rd); chk("R8 status write ctrl intact", rd, 32'h0);
    do_rd(8'h24, 8'h00, rd); chk("R8 status write status intact", rd, 32'h0);
    do_wr(8'h2C, 32'h0000_0017);
    do_rd(8'h20, 8'h00, rd); chk("R8 unmapped write ignored", rd, 32'h0);
    wr_ctrl_chk("R8 upper bits zero R2", 32'hFFFF_FF17);
    rd_i = 0;
    @(negedge clk); chk("R8 rdata holds", rdata_o, {24'b0, ctrl_m});

    // R3 / R4 directed
    wr_ctrl_chk("R3 setup", 32'h05);
    wr_ctrl_chk("R3 qualified rise", 32'h85);
    chk("R3 enable set", {31'b0, dbg_access_en_o}, 32'h1);
    wr_ctrl_chk("R4 write while set clears", 32'h85);
    chk("R4 enable cleared", {31'b0, dbg_access_en_o}, 32'h0);
    wr_ctrl_chk("R4 rewrite rearms", 32'h85);
    wr_ctrl_chk("R4 other bits take value", 32'h07);
    wr_ctrl_chk("R3 bits changed in same write", 32'h85);
    chk("R3 no enable on bit change", {31'b0, dbg_access_en_o}, 32'h0);
    wr_ctrl_chk("R3 debug reset set", 32'h40);
    wr_ctrl_chk("R3 blocked by debug reset", 32'hC0);
    chk("R3 no enable under reset", {31'b0, dbg_access_en_o}, 32'h0);
    wr_ctrl_chk("R3 release", 32'h00);
    wr_ctrl_chk("R3 set with reset in write", 32'hC0);

    // R2 R3 R4 exhaustive write sweep
    for (int v = 0; v < 256; v++) wr_ctrl_chk("R2 R3 R4 sweep", 32'(v));
    for (int v = 0; v < 128; v++) begin
      wr_ctrl_chk("R2 R3 base", 32'(v));
      wr_ctrl_chk("R3 arm attempt", 32'(v) | 32'h80);
      wr_ctrl_chk("R4 second write", 32'(v) | 32'h80);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule